// File: doc/BRIEF.md
# Asynchronous FIFO Bus Host Controller

This block is the host side of a byte-wide, strobe-driven FIFO bus. It runs on one synchronous system clock. It watches two active-low flags from the peripheral: one says a received byte is waiting, and the other says there is room for a byte to be sent. It drives two active-low strobes, one for read and one for write, on a single shared data bus. Each nanosecond minimum of the bus is set as a parameter in clock cycles: strobe width, sample delay, write setup, write hold and bus turnaround.

On the core side, received bytes leave through a one-entry valid/ready output slot. Bytes to send enter through a valid/ready input. Both flags pass through two-flop synchronizers. After any strobe, the controller issues no further strobe of that type until it has seen the matching flag go inactive and then active again. When a read and a write are both possible, they take turns.

The control is a six-state machine:
- `IDLE`: arbitrates between the two directions.
  - `IDLE -> RD_LOW` when a read is granted.
  - `IDLE -> WR_SETUP` when a write is granted.
- `RD_LOW`: holds the read strobe low.
  - `RD_LOW -> TURN` at timer expiry, capturing the bus.
- `WR_SETUP`: drives the bus with the read and write strobes high.
  - `WR_SETUP -> WR_LOW` at expiry.
- `WR_LOW`: holds the write strobe low.
  - `WR_LOW -> WR_HOLD` at expiry.
- `WR_HOLD`: keeps driving the bus after the write strobe rises.
  - `WR_HOLD -> TURN` at expiry.
- `TURN`: keeps the bus released and both strobes high.
  - `TURN -> IDLE` at expiry.

Top module: `afh_host_ctrl`

## Requirements
- R1: While reset is asserted and right after it, both strobes are high, the bus driver is off, `rx_valid_o` is 0 and `tx_ready_o` is 0.
- R2: A read strobe starts only when the synchronized receive flag is low and the output slot is empty or is being emptied in the same cycle. The read strobe stays low for exactly max(RD_PULSE_CYC, RD_SAMPLE_CYC) cycles.
- R3: The byte on `bus_din_i` at the clock edge that ends the read pulse appears on `rx_data_o` with `rx_valid_o` = 1. It stays there, unchanged, until a cycle in which `rx_ready_i` is 1.
- R4: `tx_ready_o` is 1 only in a cycle where `tx_valid_i` is 1, the synchronized transmit flag is low, no write recovery is pending and the machine is in `IDLE`. The accepted byte is the one driven on the bus for that write.
- R5: For a write, the bus driver is on for exactly WR_SETUP_CYC cycles before the write strobe falls. The write strobe stays low for exactly WR_PULSE_CYC cycles. The driver stays on for exactly WR_HOLD_CYC cycles after the strobe rises.
- R6: After a strobe, no strobe of the same type is issued until the synchronized flag has been seen high and is low again.
- R7: When a read and a write are both eligible in `IDLE`, the direction not used by the last transfer wins. Read wins the first tie after reset.
- R8: After every transfer, at least TURN_CYC cycles pass with the bus driver off and both strobes high before the next strobe or driver enable. The two strobes are never low together, and the driver is never on while the read strobe is low.
- R9: A flag change at the pins acts on the strobes on the third rising clock edge after it. The receive flag falling with everything else idle gives a read strobe falling on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_avail_ni | input | 1 | Peripheral flag, low while a byte can be read (asynchronous) |
| tx_space_ni | input | 1 | Peripheral flag, low while a byte can be written (asynchronous) |
| rd_strobe_no | output | 1 | Active-low read strobe |
| wr_strobe_no | output | 1 | Active-low write strobe |
| bus_din_i | input | DATA_W | Data bus as seen from the pads |
| bus_dout_o | output | DATA_W | Data the host drives onto the bus |
| bus_oe_o | output | 1 | Host bus driver enable |
| rx_data_o | output | DATA_W | Received byte toward the core |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Core accepts the received byte |
| tx_data_i | input | DATA_W | Byte from the core to send |
| tx_valid_i | input | 1 | Byte to send is valid |
| tx_ready_o | output | 1 | Controller accepts the byte this cycle |

## Verification
The state register and all bus outputs change on the same clock edge, so a strobe or driver change appears one edge after the decision that caused it. A pin-level flag change reaches the strobes on the third edge, and a captured read byte appears on `rx_valid_o` on the edge that raises the read strobe. `tx_ready_o` is combinational in `IDLE` and is valid before the edge where the handshake happens.

The bench samples every output at the falling clock edge. It samples the handshake signals one time step after driving its own inputs. It counts pulse widths, setup and hold in whole cycles between those samples. Each count is compared with the cycle count the requirement gives, and the R9 latency is checked at exactly the first, second and third sample after the flag falls.

// File: rtl/afh_pkg.sv
package afh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_LOW   = 3'd1,
        ST_WR_SETUP = 3'd2,
        ST_WR_LOW   = 3'd3,
        ST_WR_HOLD  = 3'd4,
        ST_TURN     = 3'd5
    } afh_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/afh_flag_sync.sv
module afh_flag_sync #(
    parameter int N_FLAGS = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_FLAGS-1:0] async_i,
    output logic [N_FLAGS-1:0] sync_o
);

    // Flags are active low, so the chains reset to the inactive level.
    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[f]};
            end
        end

        assign sync_o[f] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/afh_cycle_timer.sv
module afh_cycle_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/afh_rx_slot.sv
module afh_rx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fill_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    input  logic              ready_i
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (fill_i) begin
            valid_o <= 1'b1;
            data_o  <= fill_data_i;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/afh_host_ctrl.sv
module afh_host_ctrl
    import afh_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int RD_PULSE_CYC  = 3,
    parameter int RD_SAMPLE_CYC = 2,
    parameter int WR_SETUP_CYC  = 1,
    parameter int WR_PULSE_CYC  = 3,
    parameter int WR_HOLD_CYC   = 1,
    parameter int TURN_CYC      = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_avail_ni,
    input  logic              tx_space_ni,
    output logic              rd_strobe_no,
    output logic              wr_strobe_no,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_ready_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o
);

    // The read low time must cover both the width and the sample delay.
    localparam int RD_LOW_CYC = max2(RD_PULSE_CYC, RD_SAMPLE_CYC);
    localparam int MAX_CYC    = max2(max2(RD_LOW_CYC, WR_PULSE_CYC),
                                     max2(max2(WR_SETUP_CYC, WR_HOLD_CYC), TURN_CYC));
    localparam int CNT_W      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(WR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(WR_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);

    afh_state_e       state_q, state_n;
    logic [1:0]       flags_s;
    logic             rx_flag_s, tx_flag_s;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             grant_rd, grant_wr, capture;
    logic             rd_ok, wr_ok;
    logic             rd_wait_q, wr_wait_q;
    logic             last_wr_q;
    logic             slot_free;

    afh_flag_sync #(
        .N_FLAGS (2),
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({tx_space_ni, rx_avail_ni}),
        .sync_o  (flags_s)
    );

    assign rx_flag_s = flags_s[0];
    assign tx_flag_s = flags_s[1];

    afh_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    afh_rx_slot #(
        .DATA_W (DATA_W)
    ) u_slot (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fill_i      (capture),
        .fill_data_i (bus_din_i),
        .data_o      (rx_data_o),
        .valid_o     (rx_valid_o),
        .ready_i     (rx_ready_i)
    );

    assign slot_free = !rx_valid_o || rx_ready_i;
    assign rd_ok     = !rx_flag_s && !rd_wait_q && slot_free;
    assign wr_ok     = !tx_flag_s && !wr_wait_q && tx_valid_i;

    // Next state, timer reloads, grants and capture.
    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        grant_rd = 1'b0;
        grant_wr = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_ok && (!wr_ok || last_wr_q)) begin
                    grant_rd = 1'b1;
                    state_n  = ST_RD_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RD;
                end else if (wr_ok) begin
                    grant_wr = 1'b1;
                    state_n  = ST_WR_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_RD_LOW: begin
                if (tmr_done) begin
                    capture  = 1'b1;
                    state_n  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TURN;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    state_n  = ST_WR_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WR;
                end
            end
            ST_WR_LOW: begin
                if (tmr_done) begin
                    state_n  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    state_n  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TURN;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign tx_ready_o = grant_wr;

    // State register plus arbitration and recovery memory.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            last_wr_q <= 1'b1;
            rd_wait_q <= 1'b0;
            wr_wait_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (grant_rd) begin
                last_wr_q <= 1'b0;
            end else if (grant_wr) begin
                last_wr_q <= 1'b1;
            end
            if (grant_rd) begin
                rd_wait_q <= 1'b1;
            end else if (rx_flag_s) begin
                rd_wait_q <= 1'b0;
            end
            if (grant_wr) begin
                wr_wait_q <= 1'b1;
            end else if (tx_flag_s) begin
                wr_wait_q <= 1'b0;
            end
        end
    end

    // Registered bus outputs, decoded from the next state.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_strobe_no <= 1'b1;
            wr_strobe_no <= 1'b1;
            bus_oe_o     <= 1'b0;
            bus_dout_o   <= '0;
        end else begin
            rd_strobe_no <= (state_n != ST_RD_LOW);
            wr_strobe_no <= (state_n != ST_WR_LOW);
            bus_oe_o     <= (state_n == ST_WR_SETUP) || (state_n == ST_WR_LOW) ||
                            (state_n == ST_WR_HOLD);
            if (grant_wr) begin
                bus_dout_o <= tx_data_i;
            end
        end
    end

endmodule

// File: rtl/afh_host_chk.sv
module afh_host_chk #(
    parameter int DATA_W       = 8,
    parameter int RD_LOW_CYC   = 3,
    parameter int WR_SETUP_CYC = 1,
    parameter int WR_PULSE_CYC = 3,
    parameter int TURN_CYC     = 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_strobe_no,
    input logic              wr_strobe_no,
    input logic              bus_oe_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_valid_o,
    input logic              rx_ready_i,
    input logic              tx_valid_i,
    input logic              tx_ready_o
);

    logic [15:0] rd_run, wr_run, oe_run, quiet_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_run    <= '0;
            wr_run    <= '0;
            oe_run    <= '0;
            quiet_run <= 16'hFFFF;
        end else begin
            rd_run    <= !rd_strobe_no ? rd_run + 1'b1 : '0;
            wr_run    <= !wr_strobe_no ? wr_run + 1'b1 : '0;
            oe_run    <= (bus_oe_o && wr_strobe_no) ? oe_run + 1'b1 : '0;
            quiet_run <= (rd_strobe_no && wr_strobe_no && !bus_oe_o) ?
                         ((quiet_run == 16'hFFFF) ? quiet_run : quiet_run + 1'b1) : '0;
        end
    end

    // R8
    strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_strobe_no || wr_strobe_no);

    // R8
    oe_read_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_oe_o |-> rd_strobe_no);

    // R8
    rd_turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_strobe_no) |-> quiet_run >= 16'(TURN_CYC));

    // R2
    rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_strobe_no) |-> rd_run == 16'(RD_LOW_CYC));

    // R2
    rd_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_strobe_no) |-> $past(!rx_valid_o || rx_ready_i));

    // R3
    rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

    // R4
    tx_ready_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |-> tx_valid_i);

    // R5
    wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_strobe_no) |-> wr_run == 16'(WR_PULSE_CYC));

    // R5
    wr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wr_strobe_no) |-> oe_run == 16'(WR_SETUP_CYC));

    // R5
    wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_strobe_no) |-> bus_oe_o);

endmodule

bind afh_host_ctrl afh_host_chk #(
    .DATA_W       (DATA_W),
    .RD_LOW_CYC   (RD_LOW_CYC),
    .WR_SETUP_CYC (WR_SETUP_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .TURN_CYC     (TURN_CYC)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_strobe_no (rd_strobe_no),
    .wr_strobe_no (wr_strobe_no),
    .bus_oe_o     (bus_oe_o),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o),
    .rx_ready_i   (rx_ready_i),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o)
);

// File: tb/afh_host_ctrl_tb.sv
`timescale 1ns/1ps
module afh_host_ctrl_tb_top;

    localparam int DW       = 8;
    localparam int RD_LOW   = 3;
    localparam int WR_SETUP = 1;
    localparam int WR_PULSE = 3;
    localparam int WR_HOLD  = 1;
    localparam int TURN     = 1;
    localparam int NBYTES   = 48;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          rx_avail_ni = 1'b1;
    logic          tx_space_ni = 1'b0;
    logic          rd_strobe_no, wr_strobe_no, bus_oe_o;
    logic [DW-1:0] bus_din_i = '0;
    logic [DW-1:0] bus_dout_o, rx_data_o;
    logic          rx_valid_o, tx_ready_o;
    logic          rx_ready_i = 1'b0;
    logic [DW-1:0] tx_data_i = '0;
    logic          tx_valid_i = 1'b0;

    always #5 clk_i = ~clk_i;

    afh_host_ctrl #(
        .DATA_W(DW), .SYNC_STAGES(2), .RD_PULSE_CYC(3), .RD_SAMPLE_CYC(2),
        .WR_SETUP_CYC(WR_SETUP), .WR_PULSE_CYC(WR_PULSE), .WR_HOLD_CYC(WR_HOLD),
        .TURN_CYC(TURN)
    ) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .rx_avail_ni(rx_avail_ni),
        .tx_space_ni(tx_space_ni), .rd_strobe_no(rd_strobe_no),
        .wr_strobe_no(wr_strobe_no), .bus_din_i(bus_din_i), .bus_dout_o(bus_dout_o),
        .bus_oe_o(bus_oe_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .rx_ready_i(rx_ready_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
        .tx_ready_o(tx_ready_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0] rx_src [NBYTES];
    logic [DW-1:0] tx_src [NBYTES];

    // Peripheral model state
    int rx_head = 0, rx_n = 0, rx_rec = 0, tx_rec = 0, tx_got = 0, viol = 0;
    int rx_rcv = 0, tx_idx = 0;
    bit rx_auto = 0, tx_auto = 0;
    bit hold_pend = 0;
    logic [DW-1:0] hold_data = '0;

    // Monitor state
    logic prev_rd = 1, prev_wr = 1, prev_oe = 0;
    int rd_run = 0, wr_run = 0, setup_run = 0, hold_run = 0, quiet = 1000;
    bit in_setup = 0, in_hold = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int recov_len();
        return 10 + int'($urandom % 6);
    endfunction

    task automatic step();
        @(negedge clk_i);
        // Timing monitors on the sampled outputs.
        if (!rd_strobe_no) rd_run++;
        else if (!prev_rd) begin
            check(rd_run == RD_LOW, "R2", "read strobe width", rd_run, RD_LOW);
            rd_run = 0;
        end
        if (!wr_strobe_no) wr_run++;
        else if (!prev_wr) begin
            check(wr_run == WR_PULSE, "R5", "write strobe width", wr_run, WR_PULSE);
            wr_run = 0;
        end
        if (bus_oe_o && !prev_oe) begin
            check(quiet >= TURN, "R8", "quiet before driver on", quiet, TURN);
            in_setup = 1; setup_run = 0;
        end
        if (!rd_strobe_no && prev_rd)
            check(quiet >= TURN, "R8", "quiet before read", quiet, TURN);
        if (in_setup && !wr_strobe_no && prev_wr) begin
            check(setup_run == WR_SETUP, "R5", "write setup", setup_run, WR_SETUP);
            in_setup = 0;
        end
        if (in_setup && wr_strobe_no) setup_run++;
        if (wr_strobe_no && !prev_wr) begin
            in_hold = 1; hold_run = 0;
        end
        if (in_hold && !bus_oe_o) begin
            check(hold_run == WR_HOLD, "R5", "write hold", hold_run, WR_HOLD);
            in_hold = 0;
        end
        if (in_hold && bus_oe_o) hold_run++;
        if (rd_strobe_no && wr_strobe_no && !bus_oe_o) quiet++; else quiet = 0;
        if (!rd_strobe_no && !wr_strobe_no) check(0, "R8", "both strobes low", 0, 1);
        // Peripheral model
        if (!rd_strobe_no && prev_rd && rx_avail_ni) viol++;
        if (!wr_strobe_no && prev_wr && tx_space_ni) viol++;
        if (rd_strobe_no && !prev_rd) begin
            rx_head++; rx_rec = recov_len();
        end
        if (!wr_strobe_no && prev_wr) tx_rec = recov_len();
        if (wr_strobe_no && !prev_wr) begin
            check(tx_got < NBYTES && bus_dout_o == tx_src[tx_got], "R4",
                  "byte written on bus", int'(bus_dout_o), int'(tx_src[tx_got % NBYTES]));
            tx_got++;
        end
        if (rx_rec > 0) rx_rec--;
        if (tx_rec > 0) tx_rec--;
        rx_avail_ni = (rx_rec != 0) || (rx_head >= rx_n);
        tx_space_ni = (tx_rec != 0);
        bus_din_i   = !rd_strobe_no ? rx_src[rx_head % NBYTES] : 8'h00;
        prev_rd = rd_strobe_no; prev_wr = wr_strobe_no; prev_oe = bus_oe_o;
        // Core-side traffic
        if (hold_pend) begin
            check(rx_valid_o && rx_data_o == hold_data, "R3", "slot held while stalled",
                  int'(rx_data_o), int'(hold_data));
            hold_pend = 0;
        end
        if (rx_auto) rx_ready_i = ($urandom % 10) < 6;
        if (tx_auto) begin
            tx_valid_i = (tx_idx < NBYTES) && (($urandom % 4) != 0);
            tx_data_i  = tx_src[tx_idx % NBYTES];
        end
        #1;
        if (rx_auto && rx_valid_o) begin
            if (rx_ready_i) begin
                check(rx_data_o == rx_src[rx_rcv % NBYTES], "R3", "received byte",
                      int'(rx_data_o), int'(rx_src[rx_rcv % NBYTES]));
                rx_rcv++;
            end else begin
                hold_pend = 1; hold_data = rx_data_o;
            end
        end
        if (tx_auto && tx_valid_i && tx_ready_o) tx_idx++;
    endtask

    initial begin
        #400000;
        check(0, "ALL", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NBYTES; i++) begin
            rx_src[i] = DW'($urandom);
            tx_src[i] = DW'($urandom);
        end
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check(rd_strobe_no && wr_strobe_no && !bus_oe_o && !rx_valid_o && !tx_ready_o,
              "R1", "outputs under reset",
              {rd_strobe_no, wr_strobe_no, bus_oe_o, rx_valid_o, tx_ready_o}, 5'b11000);
        rst_ni = 1'b1;
        step();
        check(rd_strobe_no && wr_strobe_no && !bus_oe_o && !rx_valid_o, "R1",
              "outputs after reset", {rd_strobe_no, wr_strobe_no, bus_oe_o}, 3'b110);

        // R9: flag falls during this step; strobe falls on the third edge
        rx_n = 1;
        step();
        step(); check(rd_strobe_no, "R9", "strobe after 1 edge", rd_strobe_no, 1);
        step(); check(rd_strobe_no, "R9", "strobe after 2 edges", rd_strobe_no, 1);
        step(); check(!rd_strobe_no, "R9", "strobe after 3 edges", rd_strobe_no, 0);
        repeat (8) step();
        check(rx_valid_o && rx_data_o == rx_src[0], "R3", "first byte in slot",
              int'(rx_data_o), int'(rx_src[0]));

        // R2/R6: second byte pending, slot full, so no read may start
        rx_n = 2;
        repeat (30) step();
        check(rd_strobe_no && rx_valid_o && rx_data_o == rx_src[0], "R2",
              "full slot blocks reads", int'(rx_data_o), int'(rx_src[0]));

        // R7: tie after a read, write must win
        rx_ready_i = 1; tx_valid_i = 1; tx_data_i = tx_src[0];
        #1;
        check(tx_ready_o, "R7", "write wins tie after read", tx_ready_o, 1);
        step();
        rx_ready_i = 0; tx_valid_i = 0;
        #1;
        check(rd_strobe_no && bus_oe_o, "R7", "write setup, no read", bus_oe_o, 1);
        repeat (40) step();
        check(rx_valid_o && rx_data_o == rx_src[1], "R3", "second byte after write",
              int'(rx_data_o), int'(rx_src[1]));

        // R4: write accepted while reads are blocked by the full slot
        rx_n = 3;
        tx_valid_i = 1; tx_data_i = tx_src[1];
        #1;
        check(tx_ready_o, "R4", "write accepted with slot full", tx_ready_o, 1);
        step();
        tx_valid_i = 0;
        repeat (40) step();

        // R7: tie after a write, read must win
        rx_ready_i = 1; tx_valid_i = 1; tx_data_i = tx_src[2];
        #1;
        check(!tx_ready_o, "R7", "read wins tie after write", tx_ready_o, 0);
        step();
        rx_ready_i = 0;
        #1;
        check(!rd_strobe_no, "R7", "read strobe after tie", rd_strobe_no, 0);
        for (int k = 0; k < 60; k++) begin
            step();
            if (tx_ready_o) break;
        end
        check(tx_ready_o, "R4", "pending write accepted later", tx_ready_o, 1);
        step();
        tx_valid_i = 0;
        repeat (40) step();
        check(rx_valid_o && rx_data_o == rx_src[2], "R3", "third byte",
              int'(rx_data_o), int'(rx_src[2]));

        // Random phase
        rx_rcv = 2; tx_idx = 3; rx_n = NBYTES;
        rx_auto = 1; tx_auto = 1;
        for (int k = 0; k < 20000; k++) begin
            step();
            if (rx_rcv >= NBYTES && tx_got >= NBYTES) break;
        end
        tx_valid_i = 0; rx_ready_i = 0;
        check(rx_rcv == NBYTES, "R3", "all bytes received", rx_rcv, NBYTES);
        check(tx_got == NBYTES, "R4", "all bytes written", tx_got, NBYTES);
        check(viol == 0, "R6", "strobes issued during flag recovery", viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule